// File: doc/BRIEF.md
# CAM host port cycle router

This block sits behind the 16-bit multiplexed host port of a content-addressable memory. On every clock it classifies the host cycle from three pins: an active-low enable, a command/data select and a read/write select. It then raises exactly one strobe naming the internal resource that cycle talks to. The possible resources are the instruction decoder, the address, control and segment-control registers, the next-free pointer, the two status halves, the comparand, the two masks and the array ports. The strobe is registered, so it appears one clock after the cycle is presented. A registered output enable for the bidirectional data bus comes with it.

The instruction decoder feeds back short pulses. One flags that the instruction just loaded carries an address field. Another arms a one-shot override that sends the next command cycle to a named register. Two more reselect the persistent data source or persistent data destination. The router keeps this state and resolves every cycle against it. A one-shot override outranks the address-field flag. Data cycles keep using the persistent choice until the decoder changes it. A command read under a persistent-source or persistent-destination override returns the selecting code on a small readback bus. In the source case the readback also carries a device identifier.

Top module: `cam_port_router`

## Requirements
- R1: With `port_en_n` high the cycle is deselected. On the next clock both strobe vectors are zero and `bus_oe` is low, whatever `port_data` and `port_rd` are.
- R2: With `port_en_n` low, the pair {`port_data`,`port_rd`} selects the cycle: 00 command write, 01 command read, 10 data write, 11 data read. Each enabled cycle raises exactly one strobe, one clock later. The write strobe bits are 0 instruction, 1 address, 2 control, 3 segment control, 4 comparand, 5 mask 1, 6 mask 2, 7 array at address, 8 array at next free, 9 array at best match. The read strobe bits are 0 address, 1 control, 2 segment control, 3 next free, 4 status low, 5 status high, 6 source readback, 7 destination readback, 8 comparand, 9 mask 1, 10 mask 2, 11 array at address, 12 array at best match.
- R3: A command write goes to the instruction decoder unless `aflag_set` was pulsed together with the previous enabled cycle. In that case it goes to the address register. The flag is dropped by the next enabled cycle of any type.
- R4: `ovr_set` with `ovr_tgt` 0 (address), 1 (control) or 2 (segment control) sends the next command read or command write to that register. That command cycle consumes the override. Data and deselected cycles in between leave it armed.
- R5: An override naming the next-free pointer (`ovr_tgt` 3) turns the next command read into a next-free read. A command write under it goes to the instruction decoder, because the pointer is never written.
- R6: A command read returns status low by default. A command read on the clock right after a status-low read returns status high. Any other cycle, including a deselected one or an overridden read, returns the sequence to status low.
- R7: After reset the persistent source and the persistent destination are both the comparand, so data writes and data reads strobe the comparand.
- R8: `pdst_set` with `pdst_code` 0 comparand, 1 mask 1, 2 mask 2, 3 array at address, 4 array at next free, 5 array at best match selects the data-write target. Codes 6 and 7 are ignored. The selection persists across any number of cycles.
- R9: `psrc_set` with `psrc_code` 0 comparand, 1 mask 1, 2 mask 2, 3 array at address, 4 array at best match selects the data-read source. Codes 5 to 7 are ignored.
- R10: An override with `ovr_tgt` 4 turns the next command read into a source readback. `sel_rdata` then holds `DEV_ID` in bits 15:8 and the source code in bits 2:0. `ovr_tgt` 5 gives a destination readback with the destination code in bits 2:0 and zeros elsewhere. Otherwise `sel_rdata` is zero.
- R11: `bus_oe` is high on exactly the clocks that follow an enabled read cycle, command or data.
- R12: When an armed override and a pending address flag meet the same command write, the override wins and both are consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en_n | input | 1 | Active-low port enable |
| port_data | input | 1 | 1 = data cycle, 0 = command cycle |
| port_rd | input | 1 | 1 = read, 0 = write |
| ovr_set | input | 1 | Decoder pulse: arm one-shot override |
| ovr_tgt | input | 3 | Override target code |
| aflag_set | input | 1 | Decoder pulse: loaded instruction has an address field |
| psrc_set | input | 1 | Decoder pulse: select persistent source |
| psrc_code | input | 3 | Persistent source code |
| pdst_set | input | 1 | Decoder pulse: select persistent destination |
| pdst_code | input | 3 | Persistent destination code |
| wr_stb | output | 10 | One-hot write strobes |
| rd_stb | output | 13 | One-hot read strobes |
| bus_oe | output | 1 | Data bus output enable |
| sel_rdata | output | 16 | Persistent-selection readback word |

## Verification
Two routing rules can meet on a single command write: an armed one-shot override and a pending address-field flag. The bench provokes this by pulsing both with the same instruction write. The next command write must then strobe the override's register rather than the address register, and the write after that must fall back to the instruction decoder, showing that both were consumed. A second overlap is a decoder pulse arriving on the same clock as the cycle it would affect. That cycle is judged against the old state and the new setting against the following one.

// File: rtl/cam_port_pkg.sv
package cam_port_pkg;

  localparam int WR_N = 10;
  localparam int RD_N = 13;
  localparam int CODE_W = 3;

  // write strobe positions
  localparam int W_INSTR   = 0;
  localparam int W_ADDR    = 1;
  localparam int W_CTRL    = 2;
  localparam int W_SEGC    = 3;
  localparam int W_CMP     = 4;
  localparam int W_MASK1   = 5;
  localparam int W_MASK2   = 6;
  localparam int W_ARR_AT  = 7;
  localparam int W_ARR_NF  = 8;
  localparam int W_ARR_HPM = 9;

  // read strobe positions
  localparam int RD_ADDR    = 0;
  localparam int RD_CTRL    = 1;
  localparam int RD_SEGC    = 2;
  localparam int RD_NF      = 3;
  localparam int RD_STLO    = 4;
  localparam int RD_STHI    = 5;
  localparam int RD_PSRB    = 6;
  localparam int RD_PDRB    = 7;
  localparam int RD_CMP     = 8;
  localparam int RD_MASK1   = 9;
  localparam int RD_MASK2   = 10;
  localparam int RD_ARR_AT  = 11;
  localparam int RD_ARR_HPM = 12;

  // override target codes
  localparam logic [CODE_W-1:0] OV_ADDR = 3'd0;
  localparam logic [CODE_W-1:0] OV_CTRL = 3'd1;
  localparam logic [CODE_W-1:0] OV_SEGC = 3'd2;
  localparam logic [CODE_W-1:0] OV_NF   = 3'd3;
  localparam logic [CODE_W-1:0] OV_PS   = 3'd4;
  localparam logic [CODE_W-1:0] OV_PD   = 3'd5;

  // persistent source codes
  localparam logic [CODE_W-1:0] PS_CMP     = 3'd0;
  localparam logic [CODE_W-1:0] PS_MASK1   = 3'd1;
  localparam logic [CODE_W-1:0] PS_MASK2   = 3'd2;
  localparam logic [CODE_W-1:0] PS_ARR_AT  = 3'd3;
  localparam logic [CODE_W-1:0] PS_ARR_HPM = 3'd4;

  // persistent destination codes
  localparam logic [CODE_W-1:0] PD_CMP     = 3'd0;
  localparam logic [CODE_W-1:0] PD_MASK1   = 3'd1;
  localparam logic [CODE_W-1:0] PD_MASK2   = 3'd2;
  localparam logic [CODE_W-1:0] PD_ARR_AT  = 3'd3;
  localparam logic [CODE_W-1:0] PD_ARR_NF  = 3'd4;
  localparam logic [CODE_W-1:0] PD_ARR_HPM = 3'd5;

  typedef enum logic [1:0] {
    CYC_CW = 2'b00,
    CYC_CR = 2'b01,
    CYC_DW = 2'b10,
    CYC_DR = 2'b11
  } cyc_e;

endpackage

// File: rtl/cam_cycle_decode.sv
module cam_cycle_decode
  import cam_port_pkg::*;
(
  input  logic port_en_n,
  input  logic port_data,
  input  logic port_rd,
  output logic act,
  output cyc_e cyc,
  output logic cmd_cyc,
  output logic cmd_rd
);

  always_comb begin
    act = ~port_en_n;
    case ({port_data, port_rd})
      2'b00:   cyc = CYC_CW;
      2'b01:   cyc = CYC_CR;
      2'b10:   cyc = CYC_DW;
      default: cyc = CYC_DR;
    endcase
    cmd_cyc = act & ~port_data;
    cmd_rd  = act & ~port_data & port_rd;
  end

endmodule

// File: rtl/cam_cmd_track.sv
module cam_cmd_track
  import cam_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              act,
  input  logic              cmd_cyc,
  input  logic              cmd_rd,
  input  logic              ovr_set,
  input  logic [CODE_W-1:0] ovr_tgt,
  input  logic              aflag_set,
  output logic              ovr_pend,
  output logic [CODE_W-1:0] ovr_code,
  output logic              aflag_pend,
  output logic              stat_hi
);

  logic ovr_ok;
  assign ovr_ok = ovr_set && (ovr_tgt <= OV_PD);

  // one-shot override: armed by the decoder, consumed by one command cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_pend <= 1'b0;
      ovr_code <= OV_ADDR;
    end else if (ovr_ok) begin
      ovr_pend <= 1'b1;
      ovr_code <= ovr_tgt;
    end else if (cmd_cyc) begin
      ovr_pend <= 1'b0;
    end
  end

  // address-field flag: lives until the next enabled cycle
  always_ff @(posedge clk) begin
    if (rst)            aflag_pend <= 1'b0;
    else if (aflag_set) aflag_pend <= 1'b1;
    else if (act)       aflag_pend <= 1'b0;
  end

  // status half toggle: only a default low read arms the high half
  always_ff @(posedge clk) begin
    if (rst) stat_hi <= 1'b0;
    else     stat_hi <= cmd_rd && !ovr_pend && !stat_hi;
  end

endmodule

// File: rtl/cam_persist_sel.sv
module cam_persist_sel
  import cam_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              psrc_set,
  input  logic [CODE_W-1:0] psrc_code,
  input  logic              pdst_set,
  input  logic [CODE_W-1:0] pdst_code,
  output logic [CODE_W-1:0] ps_q,
  output logic [CODE_W-1:0] pd_q
);

  always_ff @(posedge clk) begin
    if (rst)
      ps_q <= PS_CMP;
    else if (psrc_set && (psrc_code <= PS_ARR_HPM))
      ps_q <= psrc_code;
  end

  always_ff @(posedge clk) begin
    if (rst)
      pd_q <= PD_CMP;
    else if (pdst_set && (pdst_code <= PD_ARR_HPM))
      pd_q <= pdst_code;
  end

endmodule

// File: rtl/cam_strobe_gen.sv
module cam_strobe_gen
  import cam_port_pkg::*;
#(
  parameter int DW   = 16,
  parameter int ID_W = 8,
  parameter logic [ID_W-1:0] DEV_ID = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act,
  input  cyc_e              cyc,
  input  logic              ovr_pend,
  input  logic [CODE_W-1:0] ovr_code,
  input  logic              aflag_pend,
  input  logic              stat_hi,
  input  logic [CODE_W-1:0] ps_q,
  input  logic [CODE_W-1:0] pd_q,
  output logic [WR_N-1:0]   wr_stb,
  output logic [RD_N-1:0]   rd_stb,
  output logic              bus_oe,
  output logic [DW-1:0]     sel_rdata
);

  logic [WR_N-1:0] wr_n;
  logic [RD_N-1:0] rd_n;
  logic [DW-1:0]   rb_n;

  always_comb begin
    wr_n = '0;
    rd_n = '0;
    rb_n = '0;
    if (act) begin
      case (cyc)
        CYC_CW: begin
          if (ovr_pend) begin
            case (ovr_code)
              OV_ADDR: wr_n[W_ADDR]  = 1'b1;
              OV_CTRL: wr_n[W_CTRL]  = 1'b1;
              OV_SEGC: wr_n[W_SEGC]  = 1'b1;
              default: wr_n[W_INSTR] = 1'b1;
            endcase
          end else if (aflag_pend) begin
            wr_n[W_ADDR] = 1'b1;
          end else begin
            wr_n[W_INSTR] = 1'b1;
          end
        end
        CYC_CR: begin
          if (ovr_pend) begin
            case (ovr_code)
              OV_ADDR: rd_n[RD_ADDR] = 1'b1;
              OV_CTRL: rd_n[RD_CTRL] = 1'b1;
              OV_SEGC: rd_n[RD_SEGC] = 1'b1;
              OV_NF:   rd_n[RD_NF]   = 1'b1;
              OV_PS: begin
                rd_n[RD_PSRB] = 1'b1;
                rb_n[CODE_W-1:0] = ps_q;
                rb_n[DW-1 -: ID_W] = DEV_ID;
              end
              OV_PD: begin
                rd_n[RD_PDRB] = 1'b1;
                rb_n[CODE_W-1:0] = pd_q;
              end
              default: rd_n[RD_STLO] = 1'b1;
            endcase
          end else if (stat_hi) begin
            rd_n[RD_STHI] = 1'b1;
          end else begin
            rd_n[RD_STLO] = 1'b1;
          end
        end
        CYC_DW: begin
          case (pd_q)
            PD_MASK1:   wr_n[W_MASK1]   = 1'b1;
            PD_MASK2:   wr_n[W_MASK2]   = 1'b1;
            PD_ARR_AT:  wr_n[W_ARR_AT]  = 1'b1;
            PD_ARR_NF:  wr_n[W_ARR_NF]  = 1'b1;
            PD_ARR_HPM: wr_n[W_ARR_HPM] = 1'b1;
            default:    wr_n[W_CMP]     = 1'b1;
          endcase
        end
        default: begin
          case (ps_q)
            PS_MASK1:   rd_n[RD_MASK1]   = 1'b1;
            PS_MASK2:   rd_n[RD_MASK2]   = 1'b1;
            PS_ARR_AT:  rd_n[RD_ARR_AT]  = 1'b1;
            PS_ARR_HPM: rd_n[RD_ARR_HPM] = 1'b1;
            default:    rd_n[RD_CMP]     = 1'b1;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb    <= '0;
      rd_stb    <= '0;
      bus_oe    <= 1'b0;
      sel_rdata <= '0;
    end else begin
      wr_stb    <= wr_n;
      rd_stb    <= rd_n;
      bus_oe    <= act && ((cyc == CYC_CR) || (cyc == CYC_DR));
      sel_rdata <= rb_n;
    end
  end

endmodule

// File: rtl/cam_port_router.sv
module cam_port_router
  import cam_port_pkg::*;
#(
  parameter int DW   = 16,
  parameter int ID_W = 8,
  parameter logic [ID_W-1:0] DEV_ID = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_en_n,
  input  logic              port_data,
  input  logic              port_rd,
  input  logic              ovr_set,
  input  logic [CODE_W-1:0] ovr_tgt,
  input  logic              aflag_set,
  input  logic              psrc_set,
  input  logic [CODE_W-1:0] psrc_code,
  input  logic              pdst_set,
  input  logic [CODE_W-1:0] pdst_code,
  output logic [WR_N-1:0]   wr_stb,
  output logic [RD_N-1:0]   rd_stb,
  output logic              bus_oe,
  output logic [DW-1:0]     sel_rdata
);

  logic              act, cmd_cyc, cmd_rd;
  cyc_e              cyc;
  logic              ovr_pend, aflag_pend, stat_hi;
  logic [CODE_W-1:0] ovr_code, ps_q, pd_q;

  cam_cycle_decode u_dec (
    .port_en_n (port_en_n),
    .port_data (port_data),
    .port_rd   (port_rd),
    .act       (act),
    .cyc       (cyc),
    .cmd_cyc   (cmd_cyc),
    .cmd_rd    (cmd_rd)
  );

  cam_cmd_track u_trk (
    .clk        (clk),
    .rst        (rst),
    .act        (act),
    .cmd_cyc    (cmd_cyc),
    .cmd_rd     (cmd_rd),
    .ovr_set    (ovr_set),
    .ovr_tgt    (ovr_tgt),
    .aflag_set  (aflag_set),
    .ovr_pend   (ovr_pend),
    .ovr_code   (ovr_code),
    .aflag_pend (aflag_pend),
    .stat_hi    (stat_hi)
  );

  cam_persist_sel u_per (
    .clk       (clk),
    .rst       (rst),
    .psrc_set  (psrc_set),
    .psrc_code (psrc_code),
    .pdst_set  (pdst_set),
    .pdst_code (pdst_code),
    .ps_q      (ps_q),
    .pd_q      (pd_q)
  );

  cam_strobe_gen #(
    .DW     (DW),
    .ID_W   (ID_W),
    .DEV_ID (DEV_ID)
  ) u_stb (
    .clk        (clk),
    .rst        (rst),
    .act        (act),
    .cyc        (cyc),
    .ovr_pend   (ovr_pend),
    .ovr_code   (ovr_code),
    .aflag_pend (aflag_pend),
    .stat_hi    (stat_hi),
    .ps_q       (ps_q),
    .pd_q       (pd_q),
    .wr_stb     (wr_stb),
    .rd_stb     (rd_stb),
    .bus_oe     (bus_oe),
    .sel_rdata  (sel_rdata)
  );

endmodule

// File: rtl/cam_port_router_chk.sv
module cam_port_router_chk
  import cam_port_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            port_en_n,
  input logic            port_data,
  input logic            port_rd,
  input logic [WR_N-1:0] wr_stb,
  input logic [RD_N-1:0] rd_stb,
  input logic            bus_oe
);

  logic prev_act, prev_desel, prev_data, prev_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_act   <= 1'b0;
      prev_desel <= 1'b0;
      prev_data  <= 1'b0;
      prev_rd    <= 1'b0;
    end else begin
      prev_act   <= ~port_en_n;
      prev_desel <= port_en_n;
      prev_data  <= port_data;
      prev_rd    <= port_rd;
    end
  end

  // R1: a deselected cycle produces no strobe and no drive
  p_desel_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    prev_desel |-> (wr_stb == '0) && (rd_stb == '0) && !bus_oe);

  // R2: exactly one strobe per enabled cycle
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    prev_act |-> ($countones({wr_stb, rd_stb}) == 1));

  // R11: bus drive follows read cycles only
  p_oe_read_r11: assert property (@(posedge clk) disable iff (rst)
    bus_oe == (prev_act && prev_rd));

  // R3: instruction strobe only after a command write
  p_instr_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    wr_stb[W_INSTR] |-> (prev_act && !prev_data && !prev_rd));

  // R5: write strobes only after write cycles
  p_wr_after_write_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_stb != '0) |-> (prev_act && !prev_rd));

  // R6: status high read only right after a status low read
  p_stat_seq_r6: assert property (@(posedge clk) disable iff (rst)
    rd_stb[RD_STHI] |-> $past(rd_stb[RD_STLO]));

endmodule

bind cam_port_router cam_port_router_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .port_en_n (port_en_n),
  .port_data (port_data),
  .port_rd   (port_rd),
  .wr_stb    (wr_stb),
  .rd_stb    (rd_stb),
  .bus_oe    (bus_oe)
);

// File: tb/cam_port_router_test.sv
module cam_port_router_test;

  localparam int NW = 10;
  localparam int NR = 13;
  // write positions
  localparam int WI = 0, WA = 1, WC = 2, WS = 3, WCMP = 4, WM1 = 5, WM2 = 6,
                 WAT = 7, WNF = 8, WHP = 9;
  // read positions
  localparam int QA = 0, QC = 1, QS = 2, QNF = 3, QLO = 4, QHI = 5, QPS = 6,
                 QPD = 7, QCMP = 8, QM1 = 9, QM2 = 10, QAT = 11, QHP = 12;
  localparam int NONE = -1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic port_en_n = 1'b1, port_data = 1'b0, port_rd = 1'b0;
  logic ovr_set = 1'b0, aflag_set = 1'b0, psrc_set = 1'b0, pdst_set = 1'b0;
  logic [2:0] ovr_tgt = '0, psrc_code = '0, pdst_code = '0;
  logic [NW-1:0] wr_stb;
  logic [NR-1:0] rd_stb;
  logic bus_oe;
  logic [15:0] sel_rdata;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  cam_port_router uut (
    .clk(clk), .rst(rst), .port_en_n(port_en_n), .port_data(port_data),
    .port_rd(port_rd), .ovr_set(ovr_set), .ovr_tgt(ovr_tgt),
    .aflag_set(aflag_set), .psrc_set(psrc_set), .psrc_code(psrc_code),
    .pdst_set(pdst_set), .pdst_code(pdst_code), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .bus_oe(bus_oe), .sel_rdata(sel_rdata)
  );

  // present one cycle at a falling edge; return at the next falling edge,
  // when the registered result of that cycle is visible
  task automatic step(input logic en_n, input logic d, input logic r);
    port_en_n = en_n;
    port_data = d;
    port_rd   = r;
    @(posedge clk);
    #2;
    ovr_set = 1'b0; aflag_set = 1'b0; psrc_set = 1'b0; pdst_set = 1'b0;
    port_en_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cw(); step(1'b0, 1'b0, 1'b0); endtask
  task automatic cr(); step(1'b0, 1'b0, 1'b1); endtask
  task automatic dw(); step(1'b0, 1'b1, 1'b0); endtask
  task automatic dr(); step(1'b0, 1'b1, 1'b1); endtask
  task automatic idle(); step(1'b1, 1'b0, 1'b0); endtask

  task automatic chk(input string tag, input int ew, input int er, input logic eoe);
    logic [NW-1:0] xw;
    logic [NR-1:0] xr;
    xw = '0;
    xr = '0;
    if (ew >= 0) xw[ew] = 1'b1;
    if (er >= 0) xr[er] = 1'b1;
    n_tests++;
    if (wr_stb !== xw || rd_stb !== xr || bus_oe !== eoe) begin
      n_fail++;
      $display("FAIL %s: wr=%b rd=%b oe=%b expected wr=%b rd=%b oe=%b",
               tag, wr_stb, rd_stb, bus_oe, xw, xr, eoe);
    end
  endtask

  task automatic chk_rb(input string tag, input logic [15:0] exp);
    n_tests++;
    if (sel_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: sel_rdata=%h expected %h", tag, sel_rdata, exp);
    end
  endtask

  task automatic t_reset();
    chk("R1 reset state", NONE, NONE, 1'b0);
    chk_rb("R10 reset readback", 16'h0000);
    dw(); chk("R7 data write to comparand after reset", WCMP, NONE, 1'b0);
    dr(); chk("R7 data read from comparand after reset", NONE, QCMP, 1'b1);
  endtask

  task automatic t_desel();
    step(1'b1, 1'b0, 1'b0); chk("R1 deselect 00", NONE, NONE, 1'b0);
    step(1'b1, 1'b1, 1'b1); chk("R1 deselect 11", NONE, NONE, 1'b0);
    step(1'b1, 1'b0, 1'b1); chk("R1 deselect 01", NONE, NONE, 1'b0);
  endtask

  task automatic t_encoding();
    cw(); chk("R2 command write", WI, NONE, 1'b0);
    cr(); chk("R2 R11 command read", NONE, QLO, 1'b1);
    dw(); chk("R2 R11 data write", WCMP, NONE, 1'b0);
    dr(); chk("R2 R11 data read", NONE, QCMP, 1'b1);
  endtask

  task automatic t_addr_flag();
    aflag_set = 1'b1; cw(); chk("R3 instruction carrying flag", WI, NONE, 1'b0);
    cw(); chk("R3 flagged write to address", WA, NONE, 1'b0);
    cw(); chk("R3 flag consumed", WI, NONE, 1'b0);
    aflag_set = 1'b1; cw(); chk("R3 flag set again", WI, NONE, 1'b0);
    dw(); chk("R3 data cycle after flag", WCMP, NONE, 1'b0);
    cw(); chk("R3 flag dropped by data cycle", WI, NONE, 1'b0);
  endtask

  task automatic t_override();
    ovr_tgt = 3'd1; ovr_set = 1'b1; cw(); chk("R4 arming instruction", WI, NONE, 1'b0);
    dw(); chk("R4 data cycle leaves override", WCMP, NONE, 1'b0);
    idle(); chk("R4 idle leaves override", NONE, NONE, 1'b0);
    cr(); chk("R4 override read of control", NONE, QC, 1'b1);
    cr(); chk("R4 override consumed", NONE, QLO, 1'b1);
    ovr_tgt = 3'd2; ovr_set = 1'b1; cw(); chk("R4 arm segment", WI, NONE, 1'b0);
    cw(); chk("R4 override write of segment", WS, NONE, 1'b0);
    cw(); chk("R4 segment override consumed", WI, NONE, 1'b0);
    ovr_tgt = 3'd0; ovr_set = 1'b1; cw(); chk("R4 arm address", WI, NONE, 1'b0);
    cr(); chk("R4 override read of address", NONE, QA, 1'b1);
  endtask

  task automatic t_nf();
    ovr_tgt = 3'd3; ovr_set = 1'b1; cw(); chk("R5 arm next free", WI, NONE, 1'b0);
    cw(); chk("R5 next free never written", WI, NONE, 1'b0);
    cr(); chk("R5 override spent by the write", NONE, QLO, 1'b1);
    ovr_tgt = 3'd3; ovr_set = 1'b1; cw(); chk("R5 re-arm next free", WI, NONE, 1'b0);
    cr(); chk("R5 next free read", NONE, QNF, 1'b1);
  endtask

  task automatic t_status();
    dw(); chk("R6 break sequence", WCMP, NONE, 1'b0);
    cr(); chk("R6 first read low", NONE, QLO, 1'b1);
    cr(); chk("R6 second read high", NONE, QHI, 1'b1);
    cr(); chk("R6 third read low", NONE, QLO, 1'b1);
    cr(); chk("R6 fourth read high", NONE, QHI, 1'b1);
    cr(); chk("R6 low after high", NONE, QLO, 1'b1);
    dw(); chk("R6 data write between", WCMP, NONE, 1'b0);
    cr(); chk("R6 low after data write", NONE, QLO, 1'b1);
    idle(); chk("R6 idle between", NONE, NONE, 1'b0);
    cr(); chk("R6 low after idle", NONE, QLO, 1'b1);
  endtask

  task automatic t_persist_dst();
    pdst_code = 3'd2; pdst_set = 1'b1; cw(); chk("R8 select mask2", WI, NONE, 1'b0);
    dw(); chk("R8 write mask2", WM2, NONE, 1'b0);
    cr(); chk("R8 command read between", NONE, QLO, 1'b1);
    dw(); chk("R8 mask2 persists", WM2, NONE, 1'b0);
    dr(); chk("R8 source unchanged", NONE, QCMP, 1'b1);
    pdst_code = 3'd4; pdst_set = 1'b1; cw(); chk("R8 select next free", WI, NONE, 1'b0);
    dw(); chk("R8 write array next free", WNF, NONE, 1'b0);
    pdst_code = 3'd7; pdst_set = 1'b1; cw(); chk("R8 invalid code", WI, NONE, 1'b0);
    dw(); chk("R8 invalid code ignored", WNF, NONE, 1'b0);
    pdst_code = 3'd1; pdst_set = 1'b1; dw(); chk("R8 old target on select cycle", WNF, NONE, 1'b0);
    dw(); chk("R8 write mask1", WM1, NONE, 1'b0);
    pdst_code = 3'd3; pdst_set = 1'b1; idle();
    dw(); chk("R8 write array at address", WAT, NONE, 1'b0);
    pdst_code = 3'd5; pdst_set = 1'b1; idle();
    dw(); chk("R8 write array best match", WHP, NONE, 1'b0);
    pdst_code = 3'd0; pdst_set = 1'b1; idle();
    dw(); chk("R8 R7 comparand restored", WCMP, NONE, 1'b0);
  endtask

  task automatic t_persist_src();
    psrc_code = 3'd1; psrc_set = 1'b1; idle();
    dr(); chk("R9 read mask1", NONE, QM1, 1'b1);
    psrc_code = 3'd2; psrc_set = 1'b1; idle();
    dr(); chk("R9 read mask2", NONE, QM2, 1'b1);
    psrc_code = 3'd3; psrc_set = 1'b1; idle();
    dr(); chk("R9 read array at address", NONE, QAT, 1'b1);
    psrc_code = 3'd4; psrc_set = 1'b1; idle();
    dr(); chk("R9 read array best match", NONE, QHP, 1'b1);
    psrc_code = 3'd6; psrc_set = 1'b1; idle();
    dr(); chk("R9 invalid code ignored", NONE, QHP, 1'b1);
    dw(); chk("R9 destination unchanged", WCMP, NONE, 1'b0);
    psrc_code = 3'd0; psrc_set = 1'b1; idle();
    dr(); chk("R9 R7 comparand restored", NONE, QCMP, 1'b1);
  endtask

  task automatic t_readback();
    psrc_code = 3'd3; psrc_set = 1'b1;
    ovr_tgt = 3'd4; ovr_set = 1'b1; cw(); chk("R10 arm source readback", WI, NONE, 1'b0);
    cr(); chk("R10 source readback strobe", NONE, QPS, 1'b1);
    chk_rb("R10 source readback word", 16'hA503);
    pdst_code = 3'd5; pdst_set = 1'b1;
    ovr_tgt = 3'd5; ovr_set = 1'b1; cw(); chk("R10 arm destination readback", WI, NONE, 1'b0);
    chk_rb("R10 readback cleared", 16'h0000);
    cr(); chk("R10 destination readback strobe", NONE, QPD, 1'b1);
    chk_rb("R10 destination readback word", 16'h0005);
    cr(); chk("R10 override spent", NONE, QLO, 1'b1);
    chk_rb("R10 readback zero otherwise", 16'h0000);
  endtask

  task automatic t_priority();
    aflag_set = 1'b1; ovr_tgt = 3'd1; ovr_set = 1'b1;
    cw(); chk("R12 both armed", WI, NONE, 1'b0);
    cw(); chk("R12 override beats address flag", WC, NONE, 1'b0);
    cw(); chk("R12 both consumed", WI, NONE, 1'b0);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_desel();
    t_encoding();
    t_addr_flag();
    t_override();
    t_nf();
    t_status();
    t_persist_dst();
    t_persist_src();
    t_readback();
    t_priority();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule